// File: doc/BRIEF.md
# Fractional Pixel Clock-Enable Divider

This block runs on a fast reference clock and emits a one-cycle enable that marks pixel slots. The spacing between enables is a programmable ratio: a 12-bit unsigned fixed-point word with an 8-bit integer part in bits 11:4 and a fraction in sixteenths in bits 3:0. A phase accumulator adds 16 on every reference cycle. Each time the running phase reaches the ratio, the ratio is subtracted and an enable is produced. Fractional ratios are therefore met by pulse skipping: the gaps between enables alternate between the floor and the ceiling of the ratio, and the long-run average equals the ratio exactly.

Some fractional settings make the downstream clock recovery unstable, so a programmed word is quantised before it is used. When the integer part is odd, the ratio keeps only a whole or half fraction. When the integer part is even, a fraction of three quarters or more rounds up to the next integer, and any smaller fraction passes unchanged. An integer part of zero is illegal and becomes a ratio of exactly 1. The quantised ratio is latched by a load strobe, which also restarts the phase. The latched value can be read back on a port. The block drives no clock net; it produces enables only.

Top module: `pxclk_frac_gen`

## Requirements
- R1: When bit 4 of the loaded word is 1 (odd integer part, nonzero), the latched ratio equals the word with bits 2:0 cleared, so the fraction is .0 or .5.
- R2: When the integer part is even and nonzero and bits 3 and 2 are both 1, the latched ratio is the integer part plus one with the fraction bits cleared.
- R3: When the integer part is even and nonzero and bits 3:2 are not both 1, the latched ratio equals the loaded word.
- R4: A word whose integer part (bits 11:4) is zero latches as 0x010, and the enable is then high on every reference cycle.
- R5: Rounding never wraps: words 0xFEC to 0xFEF latch as 0xFF0, and 0xFFF latches as 0xFF8.
- R6: Over the D reference cycles that follow a load of ratio D, exactly 16 enables are produced.
- R7: Between successive enables, the gap in reference cycles is floor(D/16) or ceil(D/16).
- R8: In the cycle after a load, the enable is low and the read-back port already shows the new ratio. The first enable comes ceil(D/16) cycles after the load edge.
- R9: During reset the enable is low and the read-back port shows 0x010. After reset the enable is high on every cycle until the next load.
- R10: Changes on the divider word without a load strobe leave the read-back ratio unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_word | input | 12 | Requested ratio, 8.4 unsigned fixed point |
| div_load | input | 1 | Strobe: quantise and latch div_word, restart the phase |
| pix_ce | output | 1 | One-cycle pixel clock enable |
| div_eff | output | 12 | Quantised ratio currently in use |

## Verification
Words are loaded that fall into each quantisation class: odd integers with and without stray fine-fraction bits, even integers just below and at the round-up threshold, zero integer parts, and the top of the range where rounding could wrap. The read-back value separates the four quantisation branches. After each load the enables are counted over exactly D cycles, which distinguishes a correct phase step from an off-by-one compare. The gap spread exposes a divider that bunches its skipped pulses instead of spreading them. The position of the first enable after a load shows whether the phase really restarts.

// File: rtl/pxdiv_pkg.sv
package pxdiv_pkg;
  localparam int DIV_W  = 12;
  localparam int FRAC_W = 4;
  localparam int INT_W  = DIV_W - FRAC_W;
  localparam logic [DIV_W-1:0] UNITY = DIV_W'(1 << FRAC_W);
endpackage

// File: rtl/pxdiv_quant.sv
module pxdiv_quant #(
  parameter int DIV_W  = pxdiv_pkg::DIV_W,
  parameter int FRAC_W = pxdiv_pkg::FRAC_W
) (
  input  logic [DIV_W-1:0] raw,
  output logic [DIV_W-1:0] quant
);
  localparam int INT_W = DIV_W - FRAC_W;
  localparam logic [DIV_W-1:0] UNITY = DIV_W'(1 << FRAC_W);

  logic [INT_W-1:0]  int_p;
  logic [FRAC_W-1:0] frac;
  logic              round_up;

  assign int_p    = raw[DIV_W-1:FRAC_W];
  assign frac     = raw[FRAC_W-1:0];
  assign round_up = &frac[FRAC_W-1 -: 2];

  // An even integer part is at most all-ones minus one, so +1 never wraps.
  always_comb begin
    quant = raw;
    if (int_p == '0)
      quant = UNITY;
    else if (int_p[0])
      quant = {int_p, frac[FRAC_W-1], {(FRAC_W-1){1'b0}}};
    else if (round_up)
      quant = {int_p + INT_W'(1), {FRAC_W{1'b0}}};
  end
endmodule

// File: rtl/pxdiv_phase.sv
module pxdiv_phase #(
  parameter int DIV_W  = pxdiv_pkg::DIV_W,
  parameter int FRAC_W = pxdiv_pkg::FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] ratio,
  output logic             ce
);
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1 << FRAC_W);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] ratio_x;
  logic             hit;

  assign ratio_x = {1'b0, ratio};
  assign acc_sum = acc + STEP;
  assign hit     = (acc_sum >= ratio_x);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc <= '0;
      ce  <= 1'b0;
    end else begin
      acc <= hit ? (acc_sum - ratio_x) : acc_sum;
      ce  <= hit;
    end
  end

  AST_PHASE_BELOW_RATIO: assert property (@(posedge clk) disable iff (rst)
    acc < ratio_x); // R6
endmodule

// File: rtl/pxclk_frac_gen.sv
module pxclk_frac_gen #(
  parameter int DIV_W  = pxdiv_pkg::DIV_W,
  parameter int FRAC_W = pxdiv_pkg::FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_word,
  input  logic             div_load,
  output logic             pix_ce,
  output logic [DIV_W-1:0] div_eff
);
  localparam logic [DIV_W-1:0] UNITY = DIV_W'(1 << FRAC_W);

  logic [DIV_W-1:0] quant_w;

  pxdiv_quant #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_quant (
    .raw   (div_word),
    .quant (quant_w)
  );

  always_ff @(posedge clk) begin
    if (rst)
      div_eff <= UNITY;
    else if (div_load)
      div_eff <= quant_w;
  end

  pxdiv_phase #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .restart (div_load),
    .ratio   (div_eff),
    .ce      (pix_ce)
  );

  AST_ODD_HALF_ONLY: assert property (@(posedge clk) disable iff (rst)
    div_eff[FRAC_W] |-> (div_eff[FRAC_W-2:0] == '0)); // R1
  AST_EVEN_BELOW_ROUND: assert property (@(posedge clk) disable iff (rst)
    !div_eff[FRAC_W] |-> !(&div_eff[FRAC_W-1 -: 2])); // R2
  AST_INT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    div_eff[DIV_W-1:FRAC_W] != '0); // R4
  AST_CE_LOW_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    div_load |=> !pix_ce); // R8
  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (rst)
    !div_load |=> $stable(div_eff)); // R10
endmodule

// File: tb/sim_pxclk_frac_gen.sv
module sim_pxclk_frac_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] div_word = 12'h000;
  logic        div_load = 1'b0;
  logic        pix_ce;
  logic [11:0] div_eff;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  pxclk_frac_gen u0 (
    .clk(clk), .rst(rst), .div_word(div_word), .div_load(div_load),
    .pix_ce(pix_ce), .div_eff(div_eff)
  );

  localparam int NV = 13;
  localparam logic [11:0] VIN [0:NV-1] = '{
    12'h030, 12'h038, 12'h03D, 12'h024, 12'h02B, 12'h02C, 12'h02F,
    12'h005, 12'h000, 12'hFEC, 12'hFFF, 12'h01F, 12'h0A7};
  localparam logic [11:0] VEXP [0:NV-1] = '{
    12'h030, 12'h038, 12'h038, 12'h024, 12'h02B, 12'h030, 12'h030,
    12'h010, 12'h010, 12'hFF0, 12'hFF8, 12'h018, 12'h0A7};

  function automatic string tag_of(input logic [11:0] w);
    if (w[11:4] == 8'h00) return "R4";
    if (w[11:4] >= 8'hFE) return "R5";
    if (w[4]) return "R1";
    if (w[3] && w[2]) return "R2";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  task automatic load_and_measure(input logic [11:0] w, input logic [11:0] exp_d);
    int d, first, last, n_ce, gmin, gmax, flo, cei;
    d = int'(exp_d);
    flo = d / 16;
    cei = (d + 15) / 16;
    @(negedge clk);
    div_word = w;
    div_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    div_load = 1'b0;
    check(div_eff == exp_d, tag_of(w), "read-back after load", int'(div_eff), d);
    check(pix_ce == 1'b0, "R8", "enable low after load", int'(pix_ce), 0);
    first = -1; last = -1; n_ce = 0; gmin = 1 << 20; gmax = 0;
    for (int k = 1; k <= d; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (pix_ce) begin
        n_ce++;
        if (first < 0) first = k;
        if (last >= 0) begin
          if (k - last < gmin) gmin = k - last;
          if (k - last > gmax) gmax = k - last;
        end
        last = k;
      end
    end
    check(n_ce == 16, "R6", "enables in D cycles", n_ce, 16);
    check(first == cei, "R8", "first enable offset", first, cei);
    check(gmin >= flo, "R7", "shortest gap", gmin, flo);
    check(gmax <= cei, "R7", "longest gap", gmax, cei);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pix_ce == 1'b0, "R9", "enable in reset", int'(pix_ce), 0);
    check(div_eff == 12'h010, "R9", "ratio in reset", int'(div_eff), 16);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(pix_ce == 1'b1, "R9", "enable every cycle after reset", int'(pix_ce), 1);
    end

    for (int i = 0; i < NV; i++)
      load_and_measure(VIN[i], VEXP[i]);

    // R4: ratio 1 keeps the enable high continuously
    load_and_measure(12'h00F, 12'h010);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(pix_ce == 1'b1, "R4", "enable every cycle at unity", int'(pix_ce), 1);
    end

    // R10: word changes without a strobe do not alter the ratio
    load_and_measure(12'h058, 12'h058);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      div_word = 12'h100 + 12'(k * 37);
      @(posedge clk);
      @(negedge clk);
      check(div_eff == 12'h058, "R10", "ratio without strobe", int'(div_eff), 12'h058);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule